// File: doc/BRIEF.md
# Period-Match Timer with Postscaler

This block is an 8-bit up-counter that measures out a programmable period. The system clock first passes through a prescaler with three selectable ratios: 1, 4 or 16. The counter then advances once per prescaler step until it equals the period register. On the next step it returns to zero. Each return to zero gives a one-cycle match pulse, which a synchronous serial port can use as its bit clock. The same event advances a postscaler. The postscaler divides the match events by a programmable ratio from 1 to 16, and its output sets a sticky interrupt flag.

Software reaches four byte-wide registers through a simple write port and a combinational read port: the count, the period, a control byte and the interrupt flag. Writing the count or the control byte restarts the prescaler and the postscaler progress. A new setting therefore always begins a full prescale period and a full postscale sequence.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control register reads 0x00, the interrupt flag reads 0, and the match pulse is low.
- R2: Control bits [2:1] select the prescale ratio: 00 gives one count step per clock, 01 gives one step every 4 clocks, and 10 or 11 give one step every 16 clocks.
- R3: While the run bit (control bit 0) is 1, the count rises by one per prescaler step. A step taken while the count equals the period sets the count to 0x00.
- R4: The match pulse is high for exactly one cycle, in the cycle after the step that returns the count to zero. With a fixed setting, successive pulses are (period+1) × prescale ratio clocks apart.
- R5: Control bits [6:3] hold a value n. The interrupt flag is set on every (n+1)-th match, counted from the last restart of the postscaler.
- R6: The interrupt flag is bit 0 at address 3 and stays set until software writes a 0 to that bit. Writing a 1 has no effect. A set and a clear in the same cycle leave the flag set.
- R7: While the run bit is 0, the count holds its value.
- R8: A write to the count (address 0) loads the new value in place of that cycle's step. It also clears the prescaler and postscaler progress.
- R9: A write to the control register (address 2) clears the prescaler and postscaler progress and leaves the count unchanged.
- R10: If the count is above the period, it keeps rising through 0xFF to 0x00 and gives no match pulse on that wrap.
- R11: The register map is: count at address 0, period at address 1, control at address 2, and flag at address 3 (bit 0). The read port returns the addressed register combinationally. Control bit 7 and flag bits [7:1] read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| match_pulse | output | 1 | One-cycle pulse on each return of the count to zero |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The hardest state to reach from the ports is a prescaler or postscaler that holds partial progress at the moment software rewrites the count or the control byte. That progress cannot be read back. The stimulus runs the timer a known number of clocks into a 1:16 prescale, or two matches into a 1:4 postscale, then issues the write. It then samples the count or the flag one cycle before and at the exact clock where a cleared counter must produce its step. A counter that was not cleared steps early and misses that clock. Matching count values above the period are reached by loading the count directly, which exercises the wrap through 0xFF.

// File: rtl/period_timer_pkg.sv
// Package: shared sizes and types of the period-match timer.
// Assumes: one byte-wide register file with four addresses.
package period_timer_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 2;
    localparam int PRE_SEL_W  = 2;
    localparam int POST_SEL_W = 4;
    localparam int CTRL_W   = 1 + PRE_SEL_W + POST_SEL_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_FLAG   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [POST_SEL_W-1:0] post_sel;
        logic [PRE_SEL_W-1:0]  pre_sel;
        logic                  run;
    } ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
// Module: clock prescaler producing one step strobe per 1, 4 or 16 clocks.
// Assumes: sel[1]=1 gives the full 2**DIV_W ratio, sel=01 gives 2**(DIV_W/2),
// sel=00 gives 1; clr restarts the division and wins over counting.
module tmr_prescaler #(
    parameter int SEL_W = 2,
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MID_W = DIV_W / 2;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last_val;

    // Purpose: choose the terminal division value from the ratio code.
    always_comb begin
        if (sel[SEL_W-1])
            last_val = '1;
        else if (sel[0])
            last_val = DIV_W'((1 << MID_W) - 1);
        else
            last_val = '0;
    end

    assign tick = run && (div_q == last_val);

    // Purpose: advance the divider while running, restart on clear or on terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (clr)
            div_q <= '0;
        else if (run)
            div_q <= tick ? '0 : div_q + 1'b1;
    end

endmodule

// File: rtl/tmr_postscaler.sv
// Module: divides match events by sel+1 and fires on the last one.
// Assumes: evt is a single-cycle strobe; clr restarts the sequence.
module tmr_postscaler #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    logic [SEL_W-1:0] evt_cnt_q;

    assign fire = evt && (evt_cnt_q == sel);

    // Purpose: count match events, wrap after sel+1 of them.
    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_cnt_q <= '0;
        else if (clr)
            evt_cnt_q <= '0;
        else if (evt)
            evt_cnt_q <= fire ? '0 : evt_cnt_q + 1'b1;
    end

endmodule

// File: rtl/tmr_core.sv
// Module: the period counter with compare and registered match pulse.
// Assumes: tick is a one-cycle step strobe; a load takes priority over a step
// and suppresses the match of that cycle.
module tmr_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             match_evt,
    output logic             match_pulse
);
    logic [CNT_W-1:0] count_q;
    logic             match_q;
    logic             at_period;

    assign at_period = (count_q == period);
    assign match_evt = tick && at_period && !load;

    // Purpose: load, step, or return the count to zero on a period match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (tick)
            count_q <= at_period ? '0 : count_q + 1'b1;
    end

    // Purpose: register the match event as a one-cycle output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else
            match_q <= match_evt;
    end

    assign count       = count_q;
    assign match_pulse = match_q;

endmodule

// File: rtl/period_timer.sv
// Module: top of the period-match timer: register file, prescaler, counter core
// and postscaler. Assumes: single-cycle writes, combinational reads.
module period_timer
    import period_timer_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int PRE_DIV_W  = 4,
    parameter logic [CNT_W-1:0] PERIOD_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              match_pulse,
    output logic              irq_flag
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] count_q;
    logic             flag_q;
    logic             wr_count;
    logic             wr_period;
    logic             wr_ctrl;
    logic             wr_flag;
    logic             restart;
    logic             step;
    logic             match_evt;
    logic             post_fire;

    assign wr_count  = bus_wr && (bus_addr == REG_COUNT);
    assign wr_period = bus_wr && (bus_addr == REG_PERIOD);
    assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
    assign wr_flag   = bus_wr && (bus_addr == REG_FLAG);
    assign restart   = wr_count || wr_ctrl;

    // Purpose: hold the period and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_RST;
            ctrl_q   <= '0;
        end else begin
            if (wr_period)
                period_q <= bus_wdata[CNT_W-1:0];
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // Purpose: sticky interrupt flag, set by the postscaler, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (post_fire)
            flag_q <= 1'b1;
        else if (wr_flag && !bus_wdata[0])
            flag_q <= 1'b0;
    end

    tmr_prescaler #(
        .SEL_W (PRE_SEL_W),
        .DIV_W (PRE_DIV_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .clr   (restart),
        .sel   (ctrl_q.pre_sel),
        .tick  (step)
    );

    tmr_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (step),
        .load        (wr_count),
        .load_val    (bus_wdata[CNT_W-1:0]),
        .period      (period_q),
        .count       (count_q),
        .match_evt   (match_evt),
        .match_pulse (match_pulse)
    );

    tmr_postscaler #(
        .SEL_W (POST_SEL_W)
    ) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (restart),
        .evt   (match_evt),
        .sel   (ctrl_q.post_sel),
        .fire  (post_fire)
    );

    // Purpose: return the addressed register on the read port.
    always_comb begin
        case (bus_addr)
            REG_COUNT:  bus_rdata = DATA_W'(count_q);
            REG_PERIOD: bus_rdata = DATA_W'(period_q);
            REG_CTRL:   bus_rdata = DATA_W'(ctrl_q);
            default:    bus_rdata = DATA_W'(flag_q);
        endcase
    end

    assign irq_flag = flag_q;

endmodule

// File: rtl/tmr_checker.sv
// Module: property checker for the period-match timer, bound to its top.
// Assumes: the bind connects the internal count, period and run bit.
module tmr_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] period,
    input logic             run,
    input logic             match_pulse,
    input logic             irq_flag
);
    logic flag_clear_wr;
    assign flag_clear_wr = bus_wr && (bus_addr == 2'd3) && !bus_wdata[0];

    AST_MATCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> (count == '0)); // R4
    AST_MATCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && (period != '0)) |=> !match_pulse); // R4
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !bus_wr) |=> $stable(count)); // R7
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bus_wr && (count != period)) |=>
        ((count == $past(count)) || (count == CNT_W'($past(count) + 1'b1)))); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !flag_clear_wr) |=> irq_flag); // R6
    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> match_pulse); // R5

endmodule

bind period_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .count       (count_q),
    .period      (period_q),
    .run         (ctrl_q.run),
    .match_pulse (match_pulse),
    .irq_flag    (irq_flag)
);

// File: tb/sim_period_timer.sv
// Bench: scoreboard bench for the period-match timer. A driver pushes expected
// items; a monitor samples the design and compares.
module sim_period_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       match_pulse;
    logic       irq_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // sel 0..3: register read, 4: match pulse, 5: flag pin, 6: literal act
    typedef struct {
        int         sel;
        logic [7:0] exp;
        logic [7:0] act;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    event     sb_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    period_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .match_pulse (match_pulse),
        .irq_flag    (irq_flag)
    );

    // Monitor: pop expected items and compare against sampled outputs.
    initial begin
        forever begin
            @(sb_ev);
            while (sb_q.size() != 0) begin
                sb_item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                if (it.sel < 4)       act = bus_rdata;
                else if (it.sel == 4) act = {7'd0, match_pulse};
                else if (it.sel == 5) act = {7'd0, irq_flag};
                else                  act = it.act;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver: one register write, called at a falling edge; consumes one clock.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_item(input int sel, input logic [7:0] exp,
                               input logic [7:0] act, input string tag);
        sb_item_t it;
        if (sel < 4) bus_addr = sel[1:0];
        #1;
        it.sel = sel; it.exp = exp; it.act = act; it.tag = tag;
        sb_q.push_back(it);
        -> sb_ev;
        #1;
    endtask

    // Driver: measure clocks between two match pulses.
    task automatic interval(input logic [7:0] exp, input string tag);
        int n = 0;
        while (!match_pulse && n < 600) begin @(negedge clk); n++; end
        n = 0;
        do begin @(negedge clk); n++; end while (!match_pulse && n < 600);
        expect_item(6, exp, 8'(n), tag);
    endtask

    task automatic finish_sim();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_sim();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_item(0, 8'h00, 0, "R1 count reset");
        expect_item(1, 8'hFF, 0, "R1 period reset");
        expect_item(2, 8'h00, 0, "R1 ctrl reset");
        expect_item(3, 8'h00, 0, "R1 flag reset");
        expect_item(4, 8'h00, 0, "R1 match low");
        // R11 register map and reserved bits
        wr(2'd1, 8'h05);
        expect_item(1, 8'h05, 0, "R11 period readback");
        wr(2'd2, 8'hFE);
        expect_item(2, 8'h7E, 0, "R11 ctrl bit7 reads 0");
        wr(2'd2, 8'h00);
        // R3 counting at 1:1, R4 match, R5 flag at 1:1 postscale
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h01);
        idle(3);
        expect_item(0, 8'h03, 0, "R3 count after 3 steps");
        idle(3);
        expect_item(0, 8'h00, 0, "R3 return to zero after period");
        expect_item(4, 8'h01, 0, "R4 match pulse high");
        expect_item(5, 8'h01, 0, "R5 flag at 1:1 postscale");
        idle(1);
        expect_item(4, 8'h00, 0, "R4 match pulse single cycle");
        // R7 hold when stopped (write edge still steps once: count 2)
        wr(2'd2, 8'h00);
        expect_item(0, 8'h02, 0, "R7 count at stop");
        idle(5);
        expect_item(0, 8'h02, 0, "R7 count held");
        // R6 sticky flag
        wr(2'd3, 8'h01);
        expect_item(5, 8'h01, 0, "R6 write 1 ignored");
        wr(2'd3, 8'h00);
        expect_item(3, 8'h00, 0, "R6 write 0 clears");
        // R2 prescale 1:4
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h03);
        idle(8);
        expect_item(0, 8'h02, 0, "R2 1:4 count after 8 clocks");
        interval(8'd24, "R4 R2 interval 1:4 period 5");
        // R2 prescale 1:16 via both codes
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h05);
        interval(8'd32, "R2 interval code 10");
        wr(2'd2, 8'h07);
        interval(8'd32, "R2 interval code 11");
        // R5 postscale 1:4
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h02);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h19);
        idle(11);
        expect_item(5, 8'h00, 0, "R5 flag not before 4th match");
        idle(1);
        expect_item(5, 8'h01, 0, "R5 flag on 4th match");
        // R8 count write clears postscaler progress
        wr(2'd2, 8'h18);
        wr(2'd0, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h19);
        idle(6);
        wr(2'd0, 8'h00);
        idle(11);
        expect_item(5, 8'h00, 0, "R8 postscaler restarted by count write");
        idle(1);
        expect_item(5, 8'h01, 0, "R8 flag after full sequence");
        // R9 control write clears prescaler progress
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h05);
        idle(5);
        wr(2'd2, 8'h05);
        idle(15);
        expect_item(0, 8'h00, 0, "R9 no early step after ctrl write");
        idle(1);
        expect_item(0, 8'h01, 0, "R9 step after full 16");
        // R8 count write loads and clears prescaler progress
        idle(3);
        wr(2'd0, 8'h10);
        expect_item(0, 8'h10, 0, "R8 count loaded");
        idle(15);
        expect_item(0, 8'h10, 0, "R8 no early step after count write");
        idle(1);
        expect_item(0, 8'h11, 0, "R8 step after full 16");
        // R10 count above period wraps without match
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h03);
        wr(2'd0, 8'hFE);
        wr(2'd2, 8'h01);
        idle(1);
        expect_item(0, 8'hFF, 0, "R10 count rises past period");
        expect_item(4, 8'h00, 0, "R10 no match at 0xFF");
        idle(1);
        expect_item(0, 8'h00, 0, "R10 wrap to zero");
        expect_item(4, 8'h00, 0, "R10 no match on wrap");
        idle(4);
        expect_item(0, 8'h00, 0, "R10 period match after wrap");
        expect_item(4, 8'h01, 0, "R10 match after wrap");
        idle(2);
        finish_sim();
    end

endmodule